// File: doc/BRIEF.md
# Bus-Master Address Phase Generator

This block produces the address phase of memory cycles issued by a bus master on a 32-bit bus. Address and data share one set of lines, and the command code travels on four active-low lines beside them. A client presents a request made of a 32-bit lower address and a 4-bit command. The block then drives the address lines, the command lines and an address-valid strobe. When the address phase is over, it gives a one-clock hand-off pulse to the data-phase logic.

A 32-bit upper-address base register, written through a simple write port, selects the addressing mode. If the register holds zero, each cycle has a single address clock. If it holds any other value, each cycle becomes a dual address cycle. In that case the first clock carries the lower address with the dual-address command, and the second clock carries the base value as the upper address with the real command. A separate target-side decoder looks at the command lines of an incoming cycle and claims it only when it is a single address cycle.

Top module: `pci_addr_phase_gen`

## Requirements
- R1: While the base register holds zero, an accepted request produces exactly one clock with `aph_valid` high, starting in the clock after acceptance.
- R2: While the base register is non-zero, an accepted request produces exactly two consecutive clocks with `aph_valid` high.
- R3: In a single address clock, `ad_out` equals the request address and `cbe_n_out` equals the bitwise inverse of the request command, in the same clock.
- R4: In a dual address cycle, the first clock drives `ad_out` = lower address and `cbe_n_out` = ~4'b1101. The second clock drives `ad_out` = base register value and `cbe_n_out` = ~command.
- R5: The base register is sampled at the clock edge that accepts a request. A write landing on that edge, or during the address phase, affects only later requests.
- R6: After zero is written to the base register, later requests return to single address clocks.
- R7: `tgt_claim` is high exactly when `tgt_strobe` is high and the inverse of `tgt_cbe_n` differs from 4'b1101. A dual address cycle is never claimed.
- R8: `phase_done` is high for exactly one clock, in the clock after the last address clock.
- R9: `req_ready` is low from acceptance until `phase_done` has fallen. `req_valid` is ignored during that time.
- R10: After reset and whenever no address clock is active, `aph_valid` = 0, `ad_out` = 0 and `cbe_n_out` = 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Write strobe for the upper-address base register |
| base_wr_data | input | 32 | Value to write into the base register |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Lower 32 address bits of the request |
| req_cmd | input | 4 | Logical command code (active high) |
| req_ready | output | 1 | Block is idle and accepts a request |
| ad_out | output | 32 | Multiplexed address lines |
| cbe_n_out | output | 4 | Active-low command lines |
| aph_valid | output | 1 | An address clock is on the bus |
| phase_done | output | 1 | One-clock hand-off to the data phase |
| tgt_strobe | input | 1 | First address clock of an incoming cycle |
| tgt_cbe_n | input | 4 | Active-low command lines of the incoming cycle |
| tgt_claim | output | 1 | Incoming cycle is single-address and may be claimed |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 4-bit command and a dual-address code of 4'b1101. These values let the bench check the full upper-word transfer with distinctive bit patterns. They also let it decode the exact dual code on the target side, next to neighbouring codes that must still be claimed. Base-register writes are timed to land on the accepting edge and inside a running phase, so the sampling rule is tested at both of its boundaries.

// File: rtl/aph_pkg.sv
package aph_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2,
        ST_DONE = 2'd3
    } aph_state_e;

    localparam logic [3:0] DUAL_CODE_DEFAULT = 4'b1101;
endpackage

// File: rtl/upper_base_reg.sv
module upper_base_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] base_q,
    output logic         base_nz
);
    logic [W-1:0] base_d;

    always_comb begin
        base_d = base_q;
        if (wr_en) base_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base_nz = |base_q;
endmodule

// File: rtl/tgt_claim_dec.sv
module tgt_claim_dec #(
    parameter int               CMD_W    = 4,
    parameter logic [CMD_W-1:0] DUAL_CMD = 4'b1101
) (
    input  logic             strobe,
    input  logic [CMD_W-1:0] cbe_n,
    output logic             claim
);
    logic [CMD_W-1:0] cmd_pos;

    always_comb begin
        cmd_pos = ~cbe_n;
        claim   = strobe && (cmd_pos != DUAL_CMD);
    end
endmodule

// File: rtl/aph_sequencer.sv
module aph_sequencer
    import aph_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter int               CMD_W    = 4,
    parameter logic [CMD_W-1:0] DUAL_CMD = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              base_nz,
    output logic              req_ready,
    output logic [ADDR_W-1:0] ad_out,
    output logic [CMD_W-1:0]  cbe_n_out,
    output logic              aph_valid,
    output logic              phase_done
);
    localparam logic [CMD_W-1:0] CBE_IDLE = '1;

    typedef struct packed {
        aph_state_e       state;
        logic [ADDR_W-1:0] ad;
        logic [CMD_W-1:0]  cbe_n;
        logic              valid;
        logic              done;
        logic              dual;
        logic [ADDR_W-1:0] hi;
        logic [CMD_W-1:0]  cmd;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.valid = 1'b0;
        s_d.ad    = '0;
        s_d.cbe_n = CBE_IDLE;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state = ST_LO;
                    s_d.dual  = base_nz;
                    s_d.hi    = base_val;
                    s_d.cmd   = req_cmd;
                    s_d.ad    = req_addr;
                    s_d.valid = 1'b1;
                    s_d.cbe_n = base_nz ? ~DUAL_CMD : ~req_cmd;
                end
            end
            ST_LO: begin
                if (s_q.dual) begin
                    s_d.state = ST_HI;
                    s_d.ad    = s_q.hi;
                    s_d.cbe_n = ~s_q.cmd;
                    s_d.valid = 1'b1;
                end else begin
                    s_d.state = ST_DONE;
                    s_d.done  = 1'b1;
                end
            end
            ST_HI: begin
                s_d.state = ST_DONE;
                s_d.done  = 1'b1;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.ad    <= '0;
            s_q.cbe_n <= CBE_IDLE;
            s_q.valid <= 1'b0;
            s_q.done  <= 1'b0;
            s_q.dual  <= 1'b0;
            s_q.hi    <= '0;
            s_q.cmd   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.state == ST_IDLE);
    assign ad_out     = s_q.ad;
    assign cbe_n_out  = s_q.cbe_n;
    assign aph_valid  = s_q.valid;
    assign phase_done = s_q.done;

    AST_SINGLE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(aph_valid) && cbe_n_out != ~DUAL_CMD) |=> (!aph_valid && phase_done)); // R1
    AST_DUAL_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(aph_valid) && cbe_n_out == ~DUAL_CMD) |=> (aph_valid && cbe_n_out != ~DUAL_CMD) ##1 (!aph_valid && phase_done)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (aph_valid || phase_done) |-> !req_ready); // R9
    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !aph_valid |-> (cbe_n_out == CBE_IDLE && ad_out == '0)); // R10
endmodule

// File: rtl/pci_addr_phase_gen.sv
module pci_addr_phase_gen
    import aph_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter int               CMD_W    = 4,
    parameter logic [CMD_W-1:0] DUAL_CMD = DUAL_CODE_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CMD_W-1:0]  req_cmd,
    output logic              req_ready,
    output logic [ADDR_W-1:0] ad_out,
    output logic [CMD_W-1:0]  cbe_n_out,
    output logic              aph_valid,
    output logic              phase_done,
    input  logic              tgt_strobe,
    input  logic [CMD_W-1:0]  tgt_cbe_n,
    output logic              tgt_claim
);
    logic [ADDR_W-1:0] base_q;
    logic              base_nz;

    upper_base_reg #(.W(ADDR_W)) i_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_q  (base_q),
        .base_nz (base_nz)
    );

    aph_sequencer #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DUAL_CMD(DUAL_CMD)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_cmd    (req_cmd),
        .base_val   (base_q),
        .base_nz    (base_nz),
        .req_ready  (req_ready),
        .ad_out     (ad_out),
        .cbe_n_out  (cbe_n_out),
        .aph_valid  (aph_valid),
        .phase_done (phase_done)
    );

    tgt_claim_dec #(.CMD_W(CMD_W), .DUAL_CMD(DUAL_CMD)) i_tgt (
        .strobe (tgt_strobe),
        .cbe_n  (tgt_cbe_n),
        .claim  (tgt_claim)
    );

    AST_NO_CLAIM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_strobe |-> !tgt_claim); // R7
endmodule

// File: tb/test_pci_addr_phase_gen.sv
`timescale 1ns/1ps
module test_pci_addr_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        req_ready, aph_valid, phase_done, tgt_claim;
    logic [31:0] ad_out;
    logic [3:0]  cbe_n_out;
    logic        tgt_strobe = 1'b0;
    logic [3:0]  tgt_cbe_n = 4'hF;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pci_addr_phase_gen i_pci_addr_phase_gen (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_cmd(req_cmd),
        .req_ready(req_ready), .ad_out(ad_out), .cbe_n_out(cbe_n_out),
        .aph_valid(aph_valid), .phase_done(phase_done),
        .tgt_strobe(tgt_strobe), .tgt_cbe_n(tgt_cbe_n), .tgt_claim(tgt_claim)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_base(input logic [31:0] v);
        base_wr_en = 1'b1; base_wr_data = v;
        step();
        base_wr_en = 1'b0;
    endtask

    // drive a request at a negedge; return at the negedge after acceptance
    task automatic issue(input logic [31:0] a, input logic [3:0] c);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        step();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset valid", {63'd0, aph_valid}, 64'd0);
        chk("R10 reset ad", {32'd0, ad_out}, 64'd0);
        chk("R10 reset cbe", {60'd0, cbe_n_out}, 64'hF);
        chk("R9 reset ready", {63'd0, req_ready}, 64'd1);
        chk("R8 reset done", {63'd0, phase_done}, 64'd0);
    endtask

    task automatic t_single(input logic [31:0] a, input logic [3:0] c);
        issue(a, c);
        chk("R1 single valid", {63'd0, aph_valid}, 64'd1);
        chk("R3 single ad", {32'd0, ad_out}, {32'd0, a});
        chk("R3 single cbe", {60'd0, cbe_n_out}, {60'd0, ~c});
        chk("R9 busy ready", {63'd0, req_ready}, 64'd0);
        step();
        chk("R1 single ends", {63'd0, aph_valid}, 64'd0);
        chk("R8 done after single", {63'd0, phase_done}, 64'd1);
        chk("R10 idle cbe", {60'd0, cbe_n_out}, 64'hF);
        step();
        chk("R8 done pulse width", {63'd0, phase_done}, 64'd0);
        chk("R9 ready again", {63'd0, req_ready}, 64'd1);
    endtask

    task automatic t_dual(input logic [31:0] a, input logic [3:0] c, input logic [31:0] hi);
        issue(a, c);
        chk("R4 dual ad lo", {32'd0, ad_out}, {32'd0, a});
        chk("R4 dual code", {60'd0, cbe_n_out}, {60'd0, ~4'b1101});
        chk("R2 dual valid1", {63'd0, aph_valid}, 64'd1);
        step();
        chk("R2 dual valid2", {63'd0, aph_valid}, 64'd1);
        chk("R4 dual ad hi", {32'd0, ad_out}, {32'd0, hi});
        chk("R4 dual cmd", {60'd0, cbe_n_out}, {60'd0, ~c});
        chk("R8 no early done", {63'd0, phase_done}, 64'd0);
        step();
        chk("R2 dual ends", {63'd0, aph_valid}, 64'd0);
        chk("R8 done after dual", {63'd0, phase_done}, 64'd1);
        step();
        chk("R8 dual done width", {63'd0, phase_done}, 64'd0);
    endtask

    task automatic t_busy_ignore();
        req_valid = 1'b1; req_addr = 32'h1111_0000; req_cmd = 4'h6;
        step();
        req_addr = 32'h2222_0000; req_cmd = 4'h7;
        step();
        chk("R9 ignored during done", {63'd0, aph_valid}, 64'd0);
        req_valid = 1'b0;
        step();
        chk("R9 no extra phase", {63'd0, aph_valid}, 64'd0);
        chk("R9 bus idle ad", {32'd0, ad_out}, 64'd0);
    endtask

    task automatic t_sample_rule();
        write_base(32'hA5A5_0001);
        req_valid = 1'b1; req_addr = 32'h0000_4000; req_cmd = 4'h7;
        base_wr_en = 1'b1; base_wr_data = 32'h0000_0000;
        step();
        req_valid = 1'b0; base_wr_en = 1'b0;
        chk("R5 same-edge write ignored", {60'd0, cbe_n_out}, {60'd0, ~4'b1101});
        step();
        chk("R5 old base used", {32'd0, ad_out}, 64'hA5A5_0001);
        step(); step();
        write_base(32'h0BAD_CAFE);
        issue(32'h0000_8000, 4'h6);
        base_wr_en = 1'b1; base_wr_data = 32'h1234_5678;
        step();
        base_wr_en = 1'b0;
        chk("R5 mid-phase write ignored", {32'd0, ad_out}, 64'h0BAD_CAFE);
        step(); step();
        t_dual(32'h0000_C000, 4'h7, 32'h1234_5678);
    endtask

    task automatic t_claim();
        tgt_strobe = 1'b0; tgt_cbe_n = ~4'h6; #1;
        chk("R7 no strobe", {63'd0, tgt_claim}, 64'd0);
        tgt_strobe = 1'b1; tgt_cbe_n = ~4'h6; #1;
        chk("R7 single read claimed", {63'd0, tgt_claim}, 64'd1);
        tgt_cbe_n = ~4'b1101; #1;
        chk("R7 dual not claimed", {63'd0, tgt_claim}, 64'd0);
        tgt_cbe_n = ~4'b1100; #1;
        chk("R7 neighbour code claimed", {63'd0, tgt_claim}, 64'd1);
        tgt_strobe = 1'b0; tgt_cbe_n = 4'hF;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_single(32'hDEAD_BEEC, 4'h6);
        t_single(32'h0000_0004, 4'h7);
        write_base(32'hFFFF_FFFF);
        t_dual(32'h1357_9BDF, 4'h6, 32'hFFFF_FFFF);
        write_base(32'h0000_0001);
        t_dual(32'h8000_0000, 4'hC, 32'h0000_0001);
        write_base(32'h0);
        t_single(32'h2468_ACE0, 4'h7); // R6
        t_busy_ignore();
        t_sample_rule();
        write_base(32'h0);
        t_single(32'h0F0F_0F00, 4'hE); // R6 after dual traffic
        t_claim();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule